// File: doc/BRIEF.md
# UART Control, Status and Interrupt Unit

This block is the register-side controller of one UART channel. A simple register bus reads and writes a small set of registers selected by a 6-bit offset. There are two mode registers behind a self-advancing pointer, a packed command register, an 8-bit status register, an interrupt status view and an interrupt mask. The unit decides when the byte in the transmit holding register is handed to an external serializer. It tracks the levels and error pulses reported by an external receive FIFO. It drives a single interrupt line.

A command byte carries three independent fields, and all three act in one write. Bits [6:4] select a channel action. Bits [3:2] control the transmitter and bits [1:0] control the receiver. The channel action is applied first, so an enable in the same byte takes effect after a reset action. Writes to the clock-select offset (0x04) and the auxiliary-control offset (0x10) are accepted and discarded.

Register map. Offset 0x00 reads or writes the mode register picked by the pointer. Offset 0x04 reads status. Offset 0x08 writes the command register. Offset 0x0C reads receive data or writes transmit data. Offset 0x14 reads the interrupt status and writes the interrupt mask. Any other read returns 0.

Status bits: 0 receiver ready, 1 FIFO full, 2 transmitter ready, 3 transmitter empty, 4 overrun, 5 parity error, 6 framing error, 7 break received.

Interrupt status bits: 0 transmit, 1 receive, 2 delta-break, 7 change-of-state. The other bits read 0.

Top module: `uart_csu`

## Requirements
- R1: After reset, status reads 0x08, the interrupt status reads 0x00, tx_en_o, rx_en_o, tx_break_o and irq_o are low, and both mode registers read 0x00.
- R2: The mode pointer starts at mode register 1 and moves to mode register 2 after one read or write at offset 0x00. It stays at mode register 2 until a command whose bits [6:4] equal 1 points it back at mode register 1.
- R3: Status bit 0 equals rx_ready_i and status bit 1 equals rx_full_i, each one cycle later. Pulses on rx_overrun_i, rx_parity_i, rx_frame_i and rx_break_i set status bits 4, 5, 6 and 7, and these bits stay set.
- R4: A write at offset 0x0C loads the holding byte and clears status bit 3. While the transmitter is enabled and bit 3 is clear, tx_load_o is high for one cycle with the byte on tx_data_o, and bit 3 is set on the next edge. While the transmitter is disabled, the byte is held.
- R5: Command bits [3:2] equal to 1 enable the transmitter and equal to 2 disable it. The value 3 changes nothing. Status bit 2 and tx_en_o follow the transmitter enable.
- R6: Command bits [1:0] control rx_en_o with the same encoding as R5.
- R7: Command action 2 disables the receiver, pulses rx_flush_o and clears status bits 0 and 1. Command action 3 disables the transmitter, sets status bit 3, clears bit 2 and discards the held byte. A transmitter enable in the same command byte still takes effect.
- R8: Command action 4 clears status bits 7:4. Action 5 clears interrupt bit 2, which a rx_break_i pulse sets. Action 6 raises tx_break_o and action 7 lowers it.
- R9: Interrupt bit 0 equals status bit 2. Interrupt bit 1 equals status bit 1 when mode register 1 bit 6 is set, and equals status bit 0 otherwise. Interrupt bit 7 equals cos_i one cycle later.
- R10: irq_o is high exactly when the interrupt status ANDed with the mask written at offset 0x14 is nonzero.
- R11: Writes at offsets 0x04 and 0x10 change no register.
- R12: A read at offset 0x0C returns rx_data_i and raises rx_pop_o in that cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the access cycle |
| tx_data_o | output | 8 | Holding byte toward the serializer |
| tx_load_o | output | 1 | Serializer takes tx_data_o this cycle |
| tx_en_o | output | 1 | Transmitter enabled |
| tx_break_o | output | 1 | Force break on the line |
| rx_en_o | output | 1 | Receiver enabled |
| rx_flush_o | output | 1 | Receive FIFO flush pulse |
| rx_pop_o | output | 1 | Receive FIFO pop pulse |
| rx_data_i | input | 8 | Receive FIFO head byte |
| rx_ready_i | input | 1 | Receive FIFO not empty |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_overrun_i | input | 1 | Overrun error pulse |
| rx_parity_i | input | 1 | Parity error pulse |
| rx_frame_i | input | 1 | Framing error pulse |
| rx_break_i | input | 1 | Break received pulse |
| cos_i | input | 1 | Change-of-state level |
| irq_o | output | 1 | Interrupt request |

## Verification
A stuck or wrong mode pointer shows on the next read at offset 0x00, because the two mode registers hold different values. A wrong enable or empty flag shows one cycle after the command or data write, either through the status read or through tx_load_o firing or failing to fire. Errors in the order of command fields, such as a reset and an enable in one byte, show as the wrong enable level on the cycle after the write. Faults in the interrupt composition show at the interrupt status read and on irq_o within one cycle of an input change, for each state of the mode bit and the mask.

// File: rtl/uart_csu_pkg.sv
package uart_csu_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFS_MODE = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h04;  // write: clock select, discarded
  localparam logic [ADDR_W-1:0] OFS_CMD  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_DATA = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_AUX  = 6'h10;  // write: aux control, discarded
  localparam logic [ADDR_W-1:0] OFS_IRQ  = 6'h14;

  localparam int unsigned SR_RXRDY = 0;
  localparam int unsigned SR_FULL  = 1;
  localparam int unsigned SR_TXRDY = 2;
  localparam int unsigned SR_TXEMP = 3;
  localparam int unsigned SR_ERR_LO = 4;
  localparam int unsigned N_ERR    = 4;

  localparam int unsigned MR_RXSEL_BIT = 6;

  typedef enum logic [2:0] {
    ACT_NOP, ACT_PTR_RST, ACT_RX_RST, ACT_TX_RST,
    ACT_ERR_RST, ACT_DB_RST, ACT_BRK_ON, ACT_BRK_OFF
  } chan_act_e;

  typedef enum logic [1:0] {EN_KEEP, EN_ON, EN_OFF, EN_RSVD} en_cmd_e;

  typedef struct packed {
    chan_act_e act;
    en_cmd_e   tx;
    en_cmd_e   rx;
  } cmd_fields_t;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic err_rst;
    logic db_rst;
    logic brk_on;
    logic brk_off;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_strobe_t;
endpackage

// File: rtl/uart_csu_cmd_dec.sv
module uart_csu_cmd_dec
  import uart_csu_pkg::*;
(
  input  logic        wr_i,
  input  logic [6:0]  cmd_i,
  output cmd_strobe_t str_o
);
  cmd_fields_t f;
  assign f = cmd_fields_t'(cmd_i);

  always_comb begin
    str_o = '0;
    if (wr_i) begin
      unique case (f.act)
        ACT_PTR_RST: str_o.ptr_rst = 1'b1;
        ACT_RX_RST:  str_o.rx_rst  = 1'b1;
        ACT_TX_RST:  str_o.tx_rst  = 1'b1;
        ACT_ERR_RST: str_o.err_rst = 1'b1;
        ACT_DB_RST:  str_o.db_rst  = 1'b1;
        ACT_BRK_ON:  str_o.brk_on  = 1'b1;
        ACT_BRK_OFF: str_o.brk_off = 1'b1;
        default: ;
      endcase
      str_o.tx_on  = (f.tx == EN_ON);
      str_o.tx_off = (f.tx == EN_OFF);
      str_o.rx_on  = (f.rx == EN_ON);
      str_o.rx_off = (f.rx == EN_OFF);
    end
  end
endmodule

// File: rtl/uart_csu_mode_regs.sv
module uart_csu_mode_regs
  import uart_csu_pkg::*;
#(
  parameter int unsigned N_MR = 2,
  parameter int unsigned W    = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         acc_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         ptr_rst_i,
  output logic [W-1:0] rdata_o,
  output logic         rx_sel_o
);
  localparam int unsigned PTR_W = (N_MR > 1) ? $clog2(N_MR) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N_MR - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [W-1:0]     mr_q [N_MR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ptr_q <= '0;
    else if (ptr_rst_i)                    ptr_q <= '0;
    else if (acc_i && ptr_q != PTR_LAST)   ptr_q <= ptr_q + 1'b1;
  end

  for (genvar g = 0; g < N_MR; g++) begin : g_mr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mr_q[g] <= '0;
      else if (acc_i && we_i && ptr_q == PTR_W'(g)) mr_q[g] <= wdata_i;
    end
  end

  assign rdata_o  = mr_q[ptr_q];
  assign rx_sel_o = mr_q[0][MR_RXSEL_BIT];

  p_ptr_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == PTR_LAST && !ptr_rst_i) |=> ptr_q == PTR_LAST);
  p_ptr_rst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_rst_i && !acc_i) |=> ptr_q == '0);
endmodule

// File: rtl/uart_csu_tx_hold.sv
module uart_csu_tx_hold
  import uart_csu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tb_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         en_on_i,
  input  logic         en_off_i,
  input  logic         tx_rst_i,
  output logic         tx_en_o,
  output logic         tx_empty_o,
  output logic         tx_load_o,
  output logic [W-1:0] tx_data_o
);
  logic         en_q, en_d, empty_q;
  logic [W-1:0] tb_q;

  // channel action first, enable field after it
  always_comb begin
    en_d = tx_rst_i ? 1'b0 : en_q;
    if (en_on_i)       en_d = 1'b1;
    else if (en_off_i) en_d = 1'b0;
  end

  assign tx_load_o = en_q & ~empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      empty_q <= 1'b1;
      tb_q    <= '0;
    end else begin
      en_q <= en_d;
      if (tb_we_i) begin
        empty_q <= 1'b0;
        tb_q    <= wdata_i;
      end else if (tx_rst_i || tx_load_o) begin
        empty_q <= 1'b1;
      end
    end
  end

  assign tx_en_o    = en_q;
  assign tx_empty_o = empty_q;
  assign tx_data_o  = tb_q;

  p_tbwr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_we_i |=> !tx_empty_o);
  p_load_then_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load_o && !tb_we_i) |=> tx_empty_o);
  p_txrst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_rst_i && !en_on_i && !tb_we_i) |=> (!tx_en_o && tx_empty_o));
endmodule

// File: rtl/uart_csu_irq.sv
module uart_csu_irq
  import uart_csu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_rdy_i,
  input  logic         rx_rdy_i,
  input  logic         rx_full_i,
  input  logic         rx_sel_i,
  input  logic         db_set_i,
  input  logic         db_clr_i,
  input  logic         cos_i,
  input  logic         imr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] isr_o,
  output logic         irq_o
);
  logic         db_q, cos_q;
  logic [W-1:0] imr_q;
  logic         rx_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_q  <= 1'b0;
      cos_q <= 1'b0;
      imr_q <= '0;
    end else begin
      cos_q <= cos_i;
      if (db_set_i)      db_q <= 1'b1;
      else if (db_clr_i) db_q <= 1'b0;
      if (imr_we_i) imr_q <= wdata_i;
    end
  end

  assign rx_int = rx_sel_i ? rx_full_i : rx_rdy_i;

  always_comb begin
    isr_o    = '0;
    isr_o[0] = tx_rdy_i;
    isr_o[1] = rx_int;
    isr_o[2] = db_q;
    isr_o[7] = cos_q;
  end

  assign irq_o = |(isr_o & imr_q);

  p_db_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_set_i |=> isr_o[2]);
  p_db_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_clr_i && !db_set_i) |=> !isr_o[2]);
endmodule

// File: rtl/uart_csu.sv
module uart_csu
  import uart_csu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_load_o,
  output logic              tx_en_o,
  output logic              tx_break_o,
  output logic              rx_en_o,
  output logic              rx_flush_o,
  output logic              rx_pop_o,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_ready_i,
  input  logic              rx_full_i,
  input  logic              rx_overrun_i,
  input  logic              rx_parity_i,
  input  logic              rx_frame_i,
  input  logic              rx_break_i,
  input  logic              cos_i,
  output logic              irq_o
);
  logic wr, rd;
  logic mode_acc, cmd_wr, tb_wr, imr_wr;
  cmd_strobe_t str;
  logic [DATA_W-1:0] mr_rdata, isr, sr;
  logic rx_sel, tx_empty;
  logic rx_rdy_q, rx_full_q, rx_en_q, brk_q;
  logic [N_ERR-1:0] err_q, err_in;

  assign wr = bus_en_i & bus_we_i;
  assign rd = bus_en_i & ~bus_we_i;
  assign mode_acc = bus_en_i & (bus_addr_i == OFS_MODE);
  assign cmd_wr   = wr & (bus_addr_i == OFS_CMD);
  assign tb_wr    = wr & (bus_addr_i == OFS_DATA);
  assign imr_wr   = wr & (bus_addr_i == OFS_IRQ);

  uart_csu_cmd_dec u_dec (
    .wr_i  (cmd_wr),
    .cmd_i (bus_wdata_i[6:0]),
    .str_o (str)
  );

  uart_csu_mode_regs u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (mode_acc),
    .we_i      (bus_we_i),
    .wdata_i   (bus_wdata_i),
    .ptr_rst_i (str.ptr_rst),
    .rdata_o   (mr_rdata),
    .rx_sel_o  (rx_sel)
  );

  uart_csu_tx_hold u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tb_we_i    (tb_wr),
    .wdata_i    (bus_wdata_i),
    .en_on_i    (str.tx_on),
    .en_off_i   (str.tx_off),
    .tx_rst_i   (str.tx_rst),
    .tx_en_o    (tx_en_o),
    .tx_empty_o (tx_empty),
    .tx_load_o  (tx_load_o),
    .tx_data_o  (tx_data_o)
  );

  assign err_in = {rx_break_i, rx_frame_i, rx_parity_i, rx_overrun_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_rdy_q  <= 1'b0;
      rx_full_q <= 1'b0;
      rx_en_q   <= 1'b0;
      brk_q     <= 1'b0;
      err_q     <= '0;
    end else begin
      rx_rdy_q  <= str.rx_rst ? 1'b0 : rx_ready_i;
      rx_full_q <= str.rx_rst ? 1'b0 : rx_full_i;
      if (str.rx_on)                      rx_en_q <= 1'b1;
      else if (str.rx_off || str.rx_rst)  rx_en_q <= 1'b0;
      if (str.brk_on)       brk_q <= 1'b1;
      else if (str.brk_off) brk_q <= 1'b0;
      err_q <= (str.err_rst ? '0 : err_q) | err_in;
    end
  end

  always_comb begin
    sr = '0;
    sr[SR_RXRDY] = rx_rdy_q;
    sr[SR_FULL]  = rx_full_q;
    sr[SR_TXRDY] = tx_en_o;
    sr[SR_TXEMP] = tx_empty;
    sr[SR_ERR_LO +: N_ERR] = err_q;
  end

  uart_csu_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_rdy_i  (sr[SR_TXRDY]),
    .rx_rdy_i  (sr[SR_RXRDY]),
    .rx_full_i (sr[SR_FULL]),
    .rx_sel_i  (rx_sel),
    .db_set_i  (rx_break_i),
    .db_clr_i  (str.db_rst),
    .cos_i     (cos_i),
    .imr_we_i  (imr_wr),
    .wdata_i   (bus_wdata_i),
    .isr_o     (isr),
    .irq_o     (irq_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      OFS_MODE: bus_rdata_o = mr_rdata;
      OFS_STAT: bus_rdata_o = sr;
      OFS_DATA: bus_rdata_o = rx_data_i;
      OFS_IRQ:  bus_rdata_o = isr;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign rx_pop_o   = rd & (bus_addr_i == OFS_DATA);
  assign rx_flush_o = str.rx_rst;
  assign rx_en_o    = rx_en_q;
  assign tx_break_o = brk_q;

  p_flush_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_o |=> (sr[SR_RXRDY] == 1'b0 && sr[SR_FULL] == 1'b0));
  p_flush_rx_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_flush_o && !str.rx_on) |=> !rx_en_o);
  p_err_rst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (str.err_rst && err_in == '0) |=> sr[7:4] == 4'h0);
  p_err_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_overrun_i && !str.err_rst) |=> sr[SR_ERR_LO]);
endmodule

// File: tb/uart_csu_tb_top.sv
module uart_csu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 0, bus_we = 0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, tx_data, rx_data = '0;
  logic tx_load, tx_en, tx_break, rx_en, rx_flush, rx_pop, irq;
  logic rx_ready = 0, rx_full = 0, rx_ovr = 0, rx_par = 0, rx_frm = 0, rx_brk = 0, cos = 0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_csu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_data_o(tx_data), .tx_load_o(tx_load), .tx_en_o(tx_en),
    .tx_break_o(tx_break), .rx_en_o(rx_en), .rx_flush_o(rx_flush),
    .rx_pop_o(rx_pop), .rx_data_i(rx_data), .rx_ready_i(rx_ready),
    .rx_full_i(rx_full), .rx_overrun_i(rx_ovr), .rx_parity_i(rx_par),
    .rx_frame_i(rx_frm), .rx_break_i(rx_brk), .cos_i(cos), .irq_o(irq)
  );

  typedef struct packed {
    logic       we;
    logic [5:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h04, 8'h00, 8'h08, 4'd1},   // R1 status after reset
    '{1'b0, 6'h00, 8'h00, 8'h00, 4'd1},   // R1 MR1 reads 0, pointer moves
    '{1'b1, 6'h00, 8'h55, 8'h00, 4'd2},   // R2 lands in MR2
    '{1'b0, 6'h00, 8'h00, 8'h55, 4'd2},   // R2 pointer stays on MR2
    '{1'b1, 6'h08, 8'h10, 8'h00, 4'd2},   // R2 pointer reset
    '{1'b1, 6'h00, 8'h40, 8'h00, 4'd2},   // MR1 = 0x40
    '{1'b1, 6'h08, 8'h10, 8'h00, 4'd2},
    '{1'b0, 6'h00, 8'h00, 8'h40, 4'd2},
    '{1'b0, 6'h00, 8'h00, 8'h55, 4'd2},
    '{1'b1, 6'h04, 8'hFF, 8'h00, 4'd11},  // R11 clock select discarded
    '{1'b1, 6'h10, 8'hFF, 8'h00, 4'd11},  // R11 aux control discarded
    '{1'b0, 6'h04, 8'h00, 8'h08, 4'd11},
    '{1'b1, 6'h08, 8'h04, 8'h00, 4'd5},   // R5 tx enable
    '{1'b0, 6'h04, 8'h00, 8'h0C, 4'd5},
    '{1'b0, 6'h14, 8'h00, 8'h01, 4'd9},   // R9 tx interrupt bit
    '{1'b1, 6'h08, 8'h0C, 8'h00, 4'd5},   // R5 reserved tx code
    '{1'b0, 6'h04, 8'h00, 8'h0C, 4'd5},
    '{1'b1, 6'h08, 8'h08, 8'h00, 4'd5},   // R5 tx disable
    '{1'b0, 6'h04, 8'h00, 8'h08, 4'd5},
    '{1'b0, 6'h14, 8'h00, 8'h00, 4'd9}
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [7:0] exp, input string req, input string what);
    logic [7:0] d;
    bus_rd(a, d);
    chk(req, what, d, exp);
  endtask

  task automatic settle;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R1", "tx_en", {7'd0, tx_en}, 8'h00);
    chk("R1", "rx_en", {7'd0, rx_en}, 8'h00);
    chk("R1", "irq", {7'd0, irq}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) bus_wr(VECS[i].addr, VECS[i].data);
      else begin
        bus_rd(VECS[i].addr, d);
        chk($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d", i), d, VECS[i].exp);
      end
    end

    // R4: byte held while disabled, then handed over on enable
    bus_wr(6'h0C, 8'hA5);
    chk("R4", "tx_load disabled", {7'd0, tx_load}, 8'h00);
    rd_chk(6'h04, 8'h00, "R4", "status after tb write");
    chk("R4", "tx_load still held", {7'd0, tx_load}, 8'h00);
    bus_wr(6'h08, 8'h04);
    chk("R4", "tx_load on enable", {7'd0, tx_load}, 8'h01);
    chk("R4", "tx_data", tx_data, 8'hA5);
    settle();
    chk("R4", "tx_load one cycle", {7'd0, tx_load}, 8'h00);
    rd_chk(6'h04, 8'h0C, "R4", "status after handoff");
    bus_wr(6'h0C, 8'h3C);
    chk("R4", "tx_load enabled write", {7'd0, tx_load}, 8'h01);
    chk("R4", "tx_data second", tx_data, 8'h3C);

    // R3 / R9: receive levels and interrupt source select (MR1 bit6 = 1)
    @(negedge clk); rx_ready = 1;
    settle();
    rd_chk(6'h04, 8'h0D, "R3", "status rx ready");
    rd_chk(6'h14, 8'h01, "R9", "isr full-select ready only");
    @(negedge clk); rx_full = 1;
    settle();
    rd_chk(6'h04, 8'h0F, "R3", "status rx full");
    rd_chk(6'h14, 8'h03, "R9", "isr full-select full");
    bus_wr(6'h14, 8'h02);
    chk("R10", "irq rx masked in", {7'd0, irq}, 8'h01);
    @(negedge clk); rx_full = 0;
    settle();
    chk("R10", "irq after full drops", {7'd0, irq}, 8'h00);
    bus_wr(6'h08, 8'h10);
    bus_wr(6'h00, 8'h00);
    rd_chk(6'h14, 8'h03, "R9", "isr ready-select");
    chk("R10", "irq ready-select", {7'd0, irq}, 8'h01);

    // R12: receive data read
    @(negedge clk); rx_data = 8'h9E;
    chk("R12", "no pop idle", {7'd0, rx_pop}, 8'h00);
    bus_en = 1; bus_we = 0; bus_addr = 6'h0C;
    #1;
    chk("R12", "rx data", bus_rdata, 8'h9E);
    chk("R12", "pop pulse", {7'd0, rx_pop}, 8'h01);
    @(negedge clk); bus_en = 0;
    #1 chk("R12", "pop ends", {7'd0, rx_pop}, 8'h00);

    // R6: receiver enable field
    bus_wr(6'h08, 8'h01);
    chk("R6", "rx enable", {7'd0, rx_en}, 8'h01);
    bus_wr(6'h08, 8'h03);
    chk("R6", "rx reserved", {7'd0, rx_en}, 8'h01);
    bus_wr(6'h08, 8'h02);
    chk("R6", "rx disable", {7'd0, rx_en}, 8'h00);
    bus_wr(6'h08, 8'h01);

    // R7: receiver reset
    @(negedge clk); rx_full = 1;
    settle();
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 6'h08; bus_wdata = 8'h20;
    #1 chk("R7", "flush pulse", {7'd0, rx_flush}, 8'h01);
    @(posedge clk);
    @(negedge clk);
    bus_en = 0; rx_ready = 0; rx_full = 0;
    chk("R7", "rx disabled", {7'd0, rx_en}, 8'h00);
    rd_chk(6'h04, 8'h0C, "R7", "status after rx reset");

    // R7: transmitter reset discards held byte; same-byte enable wins
    bus_wr(6'h08, 8'h08);
    bus_wr(6'h0C, 8'h11);
    bus_wr(6'h08, 8'h30);
    rd_chk(6'h04, 8'h08, "R7", "status after tx reset");
    bus_wr(6'h08, 8'h34);
    chk("R7", "no load of discarded byte", {7'd0, tx_load}, 8'h00);
    chk("R7", "enable after reset in one byte", {7'd0, tx_en}, 8'h01);

    // R8: errors, break, delta-break
    @(negedge clk); rx_ovr = 1;
    @(negedge clk); rx_ovr = 0;
    rd_chk(6'h04, 8'h1C, "R3", "overrun sticky");
    @(negedge clk); rx_par = 1; rx_frm = 1; rx_brk = 1;
    @(negedge clk); rx_par = 0; rx_frm = 0; rx_brk = 0;
    rd_chk(6'h04, 8'hFC, "R3", "all error bits");
    rd_chk(6'h14, 8'h05, "R8", "delta-break set");
    bus_wr(6'h08, 8'h40);
    rd_chk(6'h04, 8'h0C, "R8", "error reset");
    rd_chk(6'h14, 8'h05, "R8", "delta-break kept by error reset");
    bus_wr(6'h08, 8'h50);
    rd_chk(6'h14, 8'h01, "R8", "delta-break cleared");
    bus_wr(6'h08, 8'h60);
    chk("R8", "break on", {7'd0, tx_break}, 8'h01);
    bus_wr(6'h08, 8'h70);
    chk("R8", "break off", {7'd0, tx_break}, 8'h00);

    // R9 / R10: change of state and mask
    bus_wr(6'h14, 8'h80);
    chk("R10", "irq masked off", {7'd0, irq}, 8'h00);
    @(negedge clk); cos = 1;
    settle();
    chk("R9", "cos irq", {7'd0, irq}, 8'h01);
    rd_chk(6'h14, 8'h81, "R9", "isr cos");
    @(negedge clk); cos = 0;
    settle();
    chk("R10", "irq cos drop", {7'd0, irq}, 8'h00);
    bus_wr(6'h14, 8'h01);
    chk("R10", "irq tx mask", {7'd0, irq}, 8'h01);
    bus_wr(6'h14, 8'h00);
    chk("R10", "irq zero mask", {7'd0, irq}, 8'h00);

    // R1: reset mid-run
    bus_wr(6'h08, 8'h65);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1", "tx_en reset", {7'd0, tx_en}, 8'h00);
    chk("R1", "rx_en reset", {7'd0, rx_en}, 8'h00);
    chk("R1", "break reset", {7'd0, tx_break}, 8'h00);
    rst_n = 1;
    rd_chk(6'h04, 8'h08, "R1", "status reset");
    rd_chk(6'h14, 8'h00, "R1", "isr reset");
    rd_chk(6'h00, 8'h00, "R1", "MR1 reset");
    rd_chk(6'h00, 8'h00, "R1", "MR2 reset");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule